// File: doc/BRIEF.md
# Modem Power-Down and Readiness Register

This block is one 16-bit control and status word in a codec's register bank. Its upper byte carries power-down requests for the modem subsystems, one bit per subsystem. Its lower byte reports which of those subsystems are ready. Only the GPIO power-down bit has storage of its own in the word. The modem reference, line1 ADC and line1 DAC bits have no storage here. They are views of bits in the master power-control word, which this block also holds. Software can use them to power those subsystems back up, but it cannot power them down through this word. The line2 and handset subsystems are not present, so their bits are fixed at zero.

The block connects to a plain register port with address, write data, write strobe and combinational read data. A second write path loads the master power bits from the master register's own address decode. Each live subsystem drives a ready input.

Top module: `pdn_status_reg`

Bit map of the word, which the requirements below rely on:

| Bit | Meaning |
|-----|---------|
| 8 | GPIO power-down (own storage) |
| 9 | modem reference off (view of master bit 3) |
| 10 | line1 ADC off (view of master bit 0) |
| 11 | line1 DAC off (view of master bit 1) |
| 15:12 | line2 and handset power-down (absent) |
| 3:0 | ready flags for the subsystems of bits 8..11 |
| 7:4 | ready flags for the absent subsystems |

## Requirements
- R1: Active-low reset sets the GPIO power-down bit to 0 and all four master power bits `mst_pd` to 0.
- R2: A read at address `REG_ADDR` returns bit 8 = GPIO power-down, bit 9 = `mst_pd[3]`, bit 10 = `mst_pd[0]` and bit 11 = `mst_pd[1]`.
- R3: Ready bit k (k = 0..3) reads 1 only when `sub_rdy[k]` is 1 and the power-down bit at position 8+k reads 0. Bits 7:4 always read 0.
- R4: A write at `REG_ADDR` with 0 in bit 9, 10 or 11 clears master bit 3, 0 or 1 respectively at the next clock edge.
- R5: A write with 1 in bit 9, 10 or 11 leaves the matching master bit unchanged.
- R6: The GPIO power-down bit takes the value of write-data bit 8 on every write at `REG_ADDR`, whether that value is 0 or 1.
- R7: Write-data bits 15:12 are ignored, and read bits 15:12 are always 0.
- R8: A write at any other address changes no state, and a read at any other address returns 0.
- R9: When `mst_we` is high, the master bits load `mst_wdata`. In the same cycle, a clear from R4 wins for its own bit, and the other bits still take the loaded value.
- R10: Master bit 2 has no view in this word and changes only through `mst_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| mst_we | input | 1 | Load strobe from the master power register's write path |
| mst_wdata | input | MST_W | Value to load into the master power bits |
| mst_pd | output | MST_W | Current master power-down bits |
| sub_rdy | input | LIVE_N | Ready inputs: GPIO, modem reference, line1 ADC, line1 DAC |

## Verification
The read view is swept over every combination of the four master bits, the GPIO bit and the four ready inputs. This tells apart a mis-routed view bit from a readiness flag that ignores power-down. The write path is swept over every master state against every pattern of the three aliased bits, with varied junk in bits 15:12. This separates a clear that hits the wrong master bit from a 1 that wrongly sets a bit, and it shows any leak from the absent subsystems. Every master load is paired with every aliased clear pattern in the same cycle to show the write priority bit by bit. Writes at the wrong address use all-zero data, which would clear every live bit if the address decode were wrong.

// File: rtl/pdn_pkg.sv
// Shared constants for the modem power-down status word.
// Assumes the word is 16 bits: power-down requests in the upper byte,
// readiness flags in the lower byte, one bit per subsystem slot.
package pdn_pkg;
    localparam int WORD_W  = 16;
    localparam int SLOT_N  = 8;   // subsystem slots in each byte
    localparam int LIVE_N  = 4;   // slots backed by real subsystems
    localparam int MST_W   = 4;   // master power bits held here
    localparam int PD_LSB  = 8;   // first power-down bit of the word

    // Slot numbers of the live subsystems
    localparam int SLOT_GPIO  = 0;
    localparam int SLOT_VREF  = 1;
    localparam int SLOT_L1ADC = 2;
    localparam int SLOT_L1DAC = 3;

    // Master bit viewed by a slot; -1 means the slot has storage of its
    // own or no subsystem at all.
    function automatic int alias_src(input int slot);
        case (slot)
            SLOT_VREF:  return 3;
            SLOT_L1ADC: return 0;
            SLOT_L1DAC: return 1;
            default:    return -1;
        endcase
    endfunction
endpackage

// File: rtl/pdn_wr_decode.sv
// Write decoder: matches the address and turns aliased power-down bits
// written as 0 into clear requests on the master bits they view.
// Assumes a single-cycle write strobe; bits written as 1 make no request.
module pdn_wr_decode
    import pdn_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] REG_ADDR = 7'h3E
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [SLOT_N-1:0] pd_wbits,   // write data bits 15:8
    output logic              addr_hit,
    output logic              wr_hit,
    output logic [MST_W-1:0]  mst_clr
);
    logic [SLOT_N-1:0] slot_clr;

    // Address compare and qualified write strobe
    always_comb begin
        addr_hit = (bus_addr == REG_ADDR);
        wr_hit   = bus_we && addr_hit;
    end

    // One clear request per slot that views a master bit
    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
        if (alias_src(s) >= 0) begin : g_alias
            assign slot_clr[s] = wr_hit && !pd_wbits[s];
        end else begin : g_plain
            assign slot_clr[s] = 1'b0;
        end
    end

    // Gather slot requests onto the master bit positions they view
    always_comb begin
        mst_clr = '0;
        for (int s = 0; s < SLOT_N; s++) begin
            if (alias_src(s) >= 0 && slot_clr[s]) begin
                mst_clr[alias_src(s)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pdn_master_bits.sv
// Master power-down bits: loaded by the master register's write path and
// cleared bit by bit by writes to the aliased view.
// Assumes a clear request in the same cycle as a load wins for its bit.
module pdn_master_bits
    import pdn_pkg::*;
#(
    parameter logic [MST_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_we,
    input  logic [MST_W-1:0] upd_val,
    input  logic [MST_W-1:0] clr_req,
    output logic [MST_W-1:0] pd_q
);
    logic [MST_W-1:0] pd_d;

    // Next state: load first, then the aliased clears override
    always_comb begin
        pd_d = upd_we ? upd_val : pd_q;
        pd_d = pd_d & ~clr_req;
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pd_q <= RST_VAL;
        else        pd_q <= pd_d;
    end
endmodule

// File: rtl/pdn_ready_gen.sv
// Builds the power-down view of the upper byte and the readiness flags
// of the lower byte. Slots without a subsystem read 0 in both bytes.
// Assumes the ready inputs are already synchronous to clk.
module pdn_ready_gen
    import pdn_pkg::*;
(
    input  logic              gpio_pd,
    input  logic [MST_W-1:0]  mst_pd,
    input  logic [LIVE_N-1:0] sub_rdy,
    output logic [SLOT_N-1:0] pd_view,
    output logic [SLOT_N-1:0] rdy_view
);
    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
        if (s == SLOT_GPIO) begin : g_own
            assign pd_view[s]  = gpio_pd;
            assign rdy_view[s] = sub_rdy[s] && !gpio_pd;
        end else if (alias_src(s) >= 0) begin : g_alias
            assign pd_view[s]  = mst_pd[alias_src(s)];
            assign rdy_view[s] = sub_rdy[s] && !mst_pd[alias_src(s)];
        end else begin : g_absent
            assign pd_view[s]  = 1'b0;
            assign rdy_view[s] = 1'b0;
        end
    end
endmodule

// File: rtl/pdn_status_reg.sv
// Modem power-down and readiness register. The top holds the GPIO
// power-down bit and the read mux, decodes writes, holds the master power
// bits, and builds the read view from them.
// Assumes reads are combinational and a read at another address returns 0.
module pdn_status_reg
    import pdn_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] REG_ADDR = 7'h3E,
    parameter logic [MST_W-1:0]  MST_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              mst_we,
    input  logic [MST_W-1:0]  mst_wdata,
    output logic [MST_W-1:0]  mst_pd,
    input  logic [LIVE_N-1:0] sub_rdy
);
    logic              addr_hit;
    logic              wr_hit;
    logic [MST_W-1:0]  mst_clr;
    logic              gpio_pd_q;
    logic [SLOT_N-1:0] pd_view;
    logic [SLOT_N-1:0] rdy_view;
    logic              unused_wdata;

    // Bits outside the live power-down slots are don't-care on writes
    assign unused_wdata = ^{bus_wdata[WORD_W-1:PD_LSB+LIVE_N],
                            bus_wdata[PD_LSB-1:0]};

    pdn_wr_decode #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR)
    ) i_dec (
        .bus_addr(bus_addr),
        .bus_we  (bus_we),
        .pd_wbits({{(SLOT_N-LIVE_N){1'b1}},
                   bus_wdata[PD_LSB+LIVE_N-1:PD_LSB]}),
        .addr_hit(addr_hit),
        .wr_hit  (wr_hit),
        .mst_clr (mst_clr)
    );

    pdn_master_bits #(
        .RST_VAL(MST_RST)
    ) i_mst (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_we (mst_we),
        .upd_val(mst_wdata),
        .clr_req(mst_clr),
        .pd_q   (mst_pd)
    );

    // GPIO power-down bit: the only slot with storage in this word
    always_ff @(posedge clk) begin
        if (!rst_n)      gpio_pd_q <= 1'b0;
        else if (wr_hit) gpio_pd_q <= bus_wdata[PD_LSB+SLOT_GPIO];
    end

    pdn_ready_gen i_rdy (
        .gpio_pd (gpio_pd_q),
        .mst_pd  (mst_pd),
        .sub_rdy (sub_rdy),
        .pd_view (pd_view),
        .rdy_view(rdy_view)
    );

    // Read mux: the assembled word on an address match, else zero
    always_comb begin
        bus_rdata = addr_hit ? {pd_view, rdy_view} : '0;
    end
endmodule

// File: rtl/pdn_status_chk.sv
// Checker for pdn_status_reg. It watches only the ports and is bound to
// every instance of the top module.
module pdn_status_chk
    import pdn_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] REG_ADDR = 7'h3E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              mst_we,
    input logic [MST_W-1:0]  mst_wdata,
    input logic [MST_W-1:0]  mst_pd
);
    logic hit;
    assign hit = (bus_addr == REG_ADDR);

    AST_CLR_VREF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit && !bus_wdata[9]) |=> !mst_pd[3]); // R4
    AST_CLR_L1ADC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit && !bus_wdata[10]) |=> !mst_pd[0]); // R4
    AST_CLR_L1DAC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit && !bus_wdata[11]) |=> !mst_pd[1]); // R4
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit && bus_wdata[9] && !mst_we) |=> (mst_pd[3] == $past(mst_pd[3]))); // R5
    AST_LOAD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_we && !(bus_we && hit)) |=> (mst_pd == $past(mst_wdata))); // R9
    AST_BIT2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_we |=> $stable(mst_pd[2])); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0)); // R8
    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[15:12] == 4'h0) && (bus_rdata[7:4] == 4'h0)); // R7
    AST_RDY_NOT_PD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((bus_rdata[3:0] & bus_rdata[11:8]) == 4'h0)); // R3
endmodule

bind pdn_status_reg pdn_status_chk #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .mst_we   (mst_we),
    .mst_wdata(mst_wdata),
    .mst_pd   (mst_pd)
);

// File: tb/test_pdn_status_reg.sv
// Self-checking bench with exhaustive sweeps of master state, write
// patterns and ready inputs. Expected values come from a small model here.
module test_pdn_status_reg;
    localparam logic [6:0] ADR = 7'h3E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = ADR;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mst_we = 1'b0;
    logic [3:0]  mst_wdata = '0;
    logic [3:0]  mst_pd;
    logic [3:0]  sub_rdy = 4'hF;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    logic [3:0] m_mst;   // model of master bits
    logic       m_gpio;  // model of GPIO power-down bit

    always #4 clk = ~clk;

    pdn_status_reg i_pdn_status_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mst_we(mst_we),
        .mst_wdata(mst_wdata), .mst_pd(mst_pd), .sub_rdy(sub_rdy)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_word(input logic [3:0] rdy);
        logic [3:0] pdv;
        pdv = {m_mst[1], m_mst[0], m_mst[3], m_gpio};
        return {4'h0, pdv, 4'h0, rdy & ~pdv};
    endfunction

    // One clock with the given strobes, then strobes released
    task automatic cycle(input logic we, input logic [6:0] a, input logic [15:0] wd,
                         input logic mwe, input logic [3:0] mwd);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; mst_we = mwe; mst_wdata = mwd;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; mst_we = 1'b0; bus_addr = ADR;
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state with all ready inputs high
        check("R1 mst_pd", {12'h0, mst_pd}, 16'h0000);
        check("R1 word", bus_rdata, 16'h000F);
        rst_n = 1'b1;
        m_mst = 4'h0; m_gpio = 1'b0;

        // R2 R3 R6: view and readiness over all states and ready inputs
        for (int mv = 0; mv < 16; mv++) begin
            for (int pv = 0; pv < 2; pv++) begin
                cycle(1'b1, ADR, 16'h0E00 | (16'(pv) << 8), 1'b1, 4'(mv));
                m_mst = 4'(mv); m_gpio = pv[0];
                for (int r = 0; r < 16; r++) begin
                    sub_rdy = 4'(r); #1;
                    check("R2/R3 read view", bus_rdata, model_word(4'(r)));
                end
            end
        end
        sub_rdy = 4'hF;

        // R4 R5 R6 R7 R10: aliased write patterns from every master state
        for (int mv = 0; mv < 16; mv++) begin
            for (int w = 0; w < 16; w++) begin
                cycle(1'b0, ADR, 16'h0, 1'b1, 4'(mv));
                m_mst = 4'(mv);
                cycle(1'b1, ADR, {4'(w) ^ 4'hA, 4'(w), 8'hFF}, 1'b0, 4'h0);
                if (!w[1]) m_mst[3] = 1'b0;
                if (!w[2]) m_mst[0] = 1'b0;
                if (!w[3]) m_mst[1] = 1'b0;
                m_gpio = w[0];
                check("R4/R5/R10 mst_pd", {12'h0, mst_pd}, {12'h0, m_mst});
                check("R6/R7 word", bus_rdata, model_word(4'hF));
            end
        end

        // R9: load and aliased clear in the same cycle
        for (int mv = 0; mv < 16; mv++) begin
            for (int uv = 0; uv < 16; uv++) begin
                for (int a = 0; a < 8; a++) begin
                    cycle(1'b0, ADR, 16'h0, 1'b1, 4'(mv));
                    cycle(1'b1, ADR, {4'h0, 3'(a), 1'b0, 8'h00}, 1'b1, 4'(uv));
                    m_mst = 4'(uv);
                    if (!a[0]) m_mst[3] = 1'b0;
                    if (!a[1]) m_mst[0] = 1'b0;
                    if (!a[2]) m_mst[1] = 1'b0;
                    check("R9 priority", {12'h0, mst_pd}, {12'h0, m_mst});
                end
            end
        end

        // R8: writes and reads at other addresses
        cycle(1'b1, ADR, 16'h0F00, 1'b1, 4'hF);
        m_mst = 4'hF; m_gpio = 1'b1;
        for (int k = 0; k < 7; k++) begin
            cycle(1'b1, ADR ^ 7'(1 << k), 16'h0000, 1'b0, 4'h0);
            check("R8 state kept", {12'h0, mst_pd}, 16'h000F);
            bus_addr = ADR ^ 7'(1 << k); #1;
            check("R8 miss read", bus_rdata, 16'h0000);
            bus_addr = ADR; #1;
            check("R8 word kept", bus_rdata, model_word(4'hF));
        end

        finish_run();
    end
endmodule